// File: doc/BRIEF.md
# Security-Banked Interrupt Priority Register File

This block stores an 8-bit priority, a group bit and a group-modifier bit for every shared peripheral interrupt. It also derives from them the security group that each interrupt belongs to. Software reaches the storage through a single-cycle register bus. The bus carries an address, a byte count, write data and a flag that marks the access as secure. An arbiter elsewhere reads the priorities and groups continuously from the flat output vectors.

When security is enabled, a non-secure agent sees a restricted view. It can reach only interrupts in non-secure group 1, and it sees their priorities through a one-bit shift. It writes into the lower half of the priority range and reads back a value scaled to the full byte. Each byte lane of one access applies these rules on its own. A multi-byte access can therefore update some interrupts and leave others untouched.

Byte windows in a 12-bit offset space:
- Priorities start at 0x400, one byte per interrupt ID.
- Group bits start at 0x080, one bit per ID.
- Modifier bits start at 0x100, one bit per ID.

All other offsets read as zero.

Top module: `prio_bank_regs`

## Requirements
- R1: Reset state: every priority is 0xAA, every group and modifier bit is 0, every derived group is code 00, and rd_data is 0.
- R2: req_size codes 0, 1 and 2 (3 also means 4) select 1, 2 and 4 bytes. Byte lane k of req_wdata and rd_data maps to interrupt ID first+k. For the priority window, first = req_addr - 0x400.
- R3: Derived group codes on irq_group (2 bits per ID): 00 secure group 0, 01 non-secure group 1, 10 secure group 1. A group bit of 1 gives 01 whatever the modifier. Modifier 1 with group bit 0 gives 10. Both bits 0 give 00.
- R4: When sec_disable is 1, the modifier bit is ignored, so code 10 never occurs. The modifier window reads zero and ignores writes. The group window and the priorities are open to every access without any shift.
- R5: With security enabled, a non-secure write to an ID in group 01 stores 0x80 | (byte >> 1).
- R6: With security enabled, a non-secure read of an ID in group 01 returns (stored << 1) & 0xFF.
- R7: With security enabled, non-secure priority lanes for IDs outside group 01 read zero and ignore writes. The other lanes of the same access still take effect.
- R8: An access whose first ID is below 32 reads zero and changes nothing. Lanes for IDs at or above NUM_IRQ read zero.
- R9: Group window: bit k of the data is the group bit of ID (req_addr - 0x080)*8 + k. Modifier window: the same layout from 0x100. With security enabled, both windows read zero and ignore writes for non-secure accesses.
- R10: rd_data holds the read result in the cycle after the read request. It is zero after any cycle without a read, and zero for unmapped offsets. Reads never change stored state.
- R11: A secure access, or any access while sec_disable is 1, reads and writes priority bytes unmodified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_disable | input | 1 | 1 = single security state |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Access is secure |
| req_addr | input | 12 | Byte offset |
| req_size | input | 2 | Byte count code |
| req_wdata | input | 32 | Write data, lane k for ID first+k |
| rd_data | output | 32 | Registered read data |
| irq_prio | output | 8*NUM_IRQ | Stored priority of each ID |
| irq_group | output | 2*NUM_IRQ | Derived group code of each ID |

## Verification
A wrong group or modifier bit appears on irq_group one cycle after the write. It changes which priority lanes a non-secure access may reach, so a later non-secure read returns a zero or a shifted byte where the other was due. A wrong stored priority is visible on irq_prio at once. It also shows on rd_data one cycle after any read of that lane, whether the read is secure (raw) or non-secure (shifted). Corrupted lane masking reveals itself in mixed accesses, where the neighbouring lanes of one write must differ in outcome.

// File: rtl/prio_bank_pkg.sv
package prio_bank_pkg;

    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 32;
    localparam int ID_W      = 10;
    localparam int FIRST_SPI = 32;

    typedef enum logic [1:0] {
        SEC_G0  = 2'b00,
        NSEC_G1 = 2'b01,
        SEC_G1  = 2'b10
    } irq_grp_e;

    typedef enum logic [1:0] {
        WIN_NONE,
        WIN_PRIO,
        WIN_GRP,
        WIN_MOD
    } win_e;

    typedef struct packed {
        win_e            win;
        logic            wr;
        logic            rd;
        logic [ID_W-1:0] first_id;
        logic [5:0]      nbits;
        logic [2:0]      nbytes;
        logic            ns_restricted;
        logic            spi_ok;
    } acc_t;

    function automatic irq_grp_e grp_decode(input logic g, input logic m,
                                            input logic sec_off);
        if (g)
            return NSEC_G1;
        else if (m && !sec_off)
            return SEC_G1;
        else
            return SEC_G0;
    endfunction

    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // restricted agents write into the upper half of the range
    function automatic logic [7:0] ns_wr_map(input logic [7:0] v);
        return {1'b1, v[7:1]};
    endfunction

    function automatic logic [7:0] ns_rd_map(input logic [7:0] v);
        return {v[6:0], 1'b0};
    endfunction

endpackage

// File: rtl/prio_bank_decode.sv
module prio_bank_decode
    import prio_bank_pkg::*;
(
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_secure,
    input  logic              sec_disable,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    output acc_t              acc
);

    always_comb begin
        acc = '0;
        if (req_addr[11:10] == 2'b01) begin
            acc.win      = WIN_PRIO;
            acc.first_id = req_addr[9:0];
        end else if (req_addr[11:7] == 5'b00001) begin
            acc.win      = WIN_GRP;
            acc.first_id = {req_addr[6:0], 3'b000};
        end else if (req_addr[11:7] == 5'b00010) begin
            acc.win      = WIN_MOD;
            acc.first_id = {req_addr[6:0], 3'b000};
        end else begin
            acc.win      = WIN_NONE;
            acc.first_id = '0;
        end
        acc.wr            = req_valid && req_write;
        acc.rd            = req_valid && !req_write;
        acc.nbytes        = size_bytes(req_size);
        acc.nbits         = {acc.nbytes, 3'b000};
        acc.ns_restricted = !sec_disable && !req_secure;
        acc.spi_ok        = acc.first_id >= ID_W'(FIRST_SPI);
    end

endmodule

// File: rtl/prio_bank_bitreg.sv
module prio_bank_bitreg
    import prio_bank_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ID_W-1:0]    first_id,
    input  logic [5:0]         nbits,
    input  logic [DATA_W-1:0]  wdata,
    output logic [NUM_IRQ-1:0] bits,
    output logic [DATA_W-1:0]  rd_val
);

    localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    for (genvar j = 0; j < NUM_IRQ; j++) begin : g_bit
        logic [ID_W-1:0] ofs;
        logic            hit;
        logic            q;
        assign ofs = ID_W'(j) - first_id;
        assign hit = (ID_W'(j) >= first_id) && (ofs < ID_W'(nbits));
        always_ff @(posedge clk) begin
            if (rst)
                q <= 1'b0;
            else if (wr_en && hit)
                q <= wdata[ofs[4:0]];
        end
        assign bits[j] = q;
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < DATA_W; i++) begin
            logic [ID_W:0] id;
            id = {1'b0, first_id} + (ID_W+1)'(i);
            if ((6'(i) < nbits) && (id < (ID_W+1)'(NUM_IRQ)))
                rd_val[i] = bits[id[IDX_W-1:0]];
        end
    end

endmodule

// File: rtl/prio_bank_prio.sv
module prio_bank_prio
    import prio_bank_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ID_W-1:0]      first_id,
    input  logic [2:0]           nbytes,
    input  logic                 ns_restricted,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [2*NUM_IRQ-1:0] grp,
    output logic [8*NUM_IRQ-1:0] prio,
    output logic [DATA_W-1:0]    rd_val
);

    localparam int   IDX_W     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
    localparam int   LANES     = DATA_W / 8;
    localparam logic [7:0] PRIO_RST = 8'hAA;

    for (genvar j = 0; j < NUM_IRQ; j++) begin : g_prio
        logic [ID_W-1:0] ofs;
        logic            hit;
        logic            allow;
        logic [7:0]      lane_byte;
        logic [7:0]      q;
        assign ofs       = ID_W'(j) - first_id;
        assign hit       = (ID_W'(j) >= first_id) && (ofs < ID_W'(nbytes));
        assign allow     = !ns_restricted || (grp[2*j +: 2] == NSEC_G1);
        assign lane_byte = wdata[8*ofs[1:0] +: 8];
        always_ff @(posedge clk) begin
            if (rst)
                q <= PRIO_RST;
            else if (wr_en && hit && allow)
                q <= ns_restricted ? ns_wr_map(lane_byte) : lane_byte;
        end
        assign prio[8*j +: 8] = q;
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < LANES; i++) begin
            logic [ID_W:0]    id;
            logic [IDX_W-1:0] idx;
            logic [1:0]       g;
            logic [7:0]       v;
            id  = {1'b0, first_id} + (ID_W+1)'(i);
            idx = id[IDX_W-1:0];
            g   = grp[2*idx +: 2];
            v   = prio[8*idx +: 8];
            if ((3'(i) < nbytes) && (id < (ID_W+1)'(NUM_IRQ))) begin
                if (!ns_restricted)
                    rd_val[8*i +: 8] = v;
                else if (g == NSEC_G1)
                    rd_val[8*i +: 8] = ns_rd_map(v);
            end
        end
    end

endmodule

// File: rtl/prio_bank_regs.sv
module prio_bank_regs
    import prio_bank_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sec_disable,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic                 req_secure,
    input  logic [11:0]          req_addr,
    input  logic [1:0]           req_size,
    input  logic [31:0]          req_wdata,
    output logic [31:0]          rd_data,
    output logic [8*NUM_IRQ-1:0] irq_prio,
    output logic [2*NUM_IRQ-1:0] irq_group
);

    acc_t               acc;
    logic [NUM_IRQ-1:0] grp_bits;
    logic [NUM_IRQ-1:0] mod_bits;
    logic [DATA_W-1:0]  grp_rd;
    logic [DATA_W-1:0]  mod_rd;
    logic [DATA_W-1:0]  prio_rd;
    logic               grp_open;
    logic               mod_open;
    logic [DATA_W-1:0]  rd_sel;
    logic [DATA_W-1:0]  rd_q;

    prio_bank_decode u_dec (
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_secure  (req_secure),
        .sec_disable (sec_disable),
        .req_addr    (req_addr),
        .req_size    (req_size),
        .acc         (acc)
    );

    assign grp_open = !acc.ns_restricted;
    assign mod_open = !sec_disable && req_secure;

    prio_bank_bitreg #(.NUM_IRQ(NUM_IRQ)) u_grp (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (acc.wr && acc.win == WIN_GRP && acc.spi_ok && grp_open),
        .first_id (acc.first_id),
        .nbits    (acc.nbits),
        .wdata    (req_wdata),
        .bits     (grp_bits),
        .rd_val   (grp_rd)
    );

    prio_bank_bitreg #(.NUM_IRQ(NUM_IRQ)) u_mod (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (acc.wr && acc.win == WIN_MOD && acc.spi_ok && mod_open),
        .first_id (acc.first_id),
        .nbits    (acc.nbits),
        .wdata    (req_wdata),
        .bits     (mod_bits),
        .rd_val   (mod_rd)
    );

    for (genvar j = 0; j < NUM_IRQ; j++) begin : g_grp
        assign irq_group[2*j +: 2] = grp_decode(grp_bits[j], mod_bits[j], sec_disable);
    end

    prio_bank_prio #(.NUM_IRQ(NUM_IRQ)) u_prio (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (acc.wr && acc.win == WIN_PRIO && acc.spi_ok),
        .first_id      (acc.first_id),
        .nbytes        (acc.nbytes),
        .ns_restricted (acc.ns_restricted),
        .wdata         (req_wdata),
        .grp           (irq_group),
        .prio          (irq_prio),
        .rd_val        (prio_rd)
    );

    always_comb begin
        rd_sel = '0;
        if (acc.spi_ok) begin
            case (acc.win)
                WIN_PRIO: rd_sel = prio_rd;
                WIN_GRP:  rd_sel = grp_open ? grp_rd : '0;
                WIN_MOD:  rd_sel = mod_open ? mod_rd : '0;
                default:  rd_sel = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_q <= '0;
        else
            rd_q <= acc.rd ? rd_sel : '0;
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/prio_bank_chk.sv
module prio_bank_chk #(
    parameter int NUM_IRQ = 64
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 sec_disable,
    input logic                 req_valid,
    input logic                 req_write,
    input logic                 req_secure,
    input logic [11:0]          req_addr,
    input logic [31:0]          rd_data,
    input logic [8*NUM_IRQ-1:0] irq_prio,
    input logic [2*NUM_IRQ-1:0] irq_group
);

    logic ns_prio_wr;
    logic low_prio_wr;
    logic any_rd;

    assign ns_prio_wr  = req_valid && req_write && !req_secure && !sec_disable
                         && (req_addr[11:10] == 2'b01);
    assign low_prio_wr = req_valid && req_write && (req_addr >= 12'h400)
                         && (req_addr < 12'h420);
    assign any_rd      = req_valid && !req_write;

    assert_rd_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(any_rd) |-> rd_data == 32'h0);

    assert_rd_no_side_R10: assert property (@(posedge clk) disable iff (rst)
        $past(any_rd) |-> ($stable(irq_prio) && $stable(irq_group)));

    assert_low_id_R8: assert property (@(posedge clk) disable iff (rst)
        $past(low_prio_wr) |-> $stable(irq_prio));

    for (genvar j = 0; j < NUM_IRQ; j++) begin : g_chk
        assert_ns_msb_R5: assert property (@(posedge clk) disable iff (rst)
            ($past(ns_prio_wr) && $past(irq_group[2*j +: 2]) == 2'b01
             && !$stable(irq_prio[8*j +: 8])) |-> irq_prio[8*j + 7]);

        assert_ns_block_R7: assert property (@(posedge clk) disable iff (rst)
            ($past(ns_prio_wr) && $past(irq_group[2*j +: 2]) != 2'b01)
            |-> $stable(irq_prio[8*j +: 8]));

        assert_no_s1_R4: assert property (@(posedge clk) disable iff (rst)
            sec_disable |-> irq_group[2*j +: 2] != 2'b10);
    end

endmodule

bind prio_bank_regs prio_bank_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sec_disable (sec_disable),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_secure  (req_secure),
    .req_addr    (req_addr),
    .rd_data     (rd_data),
    .irq_prio    (irq_prio),
    .irq_group   (irq_group)
);

// File: tb/sim_prio_bank_regs.sv
`timescale 1ns/1ps
module sim_prio_bank_regs;

    localparam int NUM_IRQ = 64;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 sec_disable = 1'b0;
    logic                 req_valid = 1'b0;
    logic                 req_write = 1'b0;
    logic                 req_secure = 1'b0;
    logic [11:0]          req_addr = '0;
    logic [1:0]           req_size = '0;
    logic [31:0]          req_wdata = '0;
    logic [31:0]          rd_data;
    logic [8*NUM_IRQ-1:0] irq_prio;
    logic [2*NUM_IRQ-1:0] irq_group;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    prio_bank_regs #(.NUM_IRQ(NUM_IRQ)) u0 (
        .clk         (clk),
        .rst         (rst),
        .sec_disable (sec_disable),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_secure  (req_secure),
        .req_addr    (req_addr),
        .req_size    (req_size),
        .req_wdata   (req_wdata),
        .rd_data     (rd_data),
        .irq_prio    (irq_prio),
        .irq_group   (irq_group)
    );

    typedef struct packed {
        logic        wr;
        logic        sec;
        logic [11:0] addr;
        logic [1:0]  sz;
        logic [31:0] wd;
        logic [31:0] ex;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 1'b1, 12'h420, 2'd2, 32'h0,        32'hAAAAAAAA, 8'd1},  // R1
        '{1'b1, 1'b1, 12'h420, 2'd2, 32'h44332211, 32'h0,        8'd11}, // R11
        '{1'b0, 1'b1, 12'h420, 2'd2, 32'h0,        32'h44332211, 8'd2},  // R2
        '{1'b1, 1'b1, 12'h430, 2'd0, 32'h0000005A, 32'h0,        8'd2},  // R2
        '{1'b0, 1'b1, 12'h430, 2'd1, 32'h0,        32'h0000AA5A, 8'd2},  // R2
        '{1'b0, 1'b0, 12'h420, 2'd2, 32'h0,        32'h0,        8'd7},  // R7
        '{1'b1, 1'b0, 12'h420, 2'd2, 32'hFFFFFFFF, 32'h0,        8'd7},  // R7
        '{1'b0, 1'b1, 12'h420, 2'd2, 32'h0,        32'h44332211, 8'd7},  // R7
        '{1'b1, 1'b1, 12'h084, 2'd0, 32'h00000005, 32'h0,        8'd9},  // R9
        '{1'b0, 1'b1, 12'h084, 2'd0, 32'h0,        32'h00000005, 8'd9},  // R9
        '{1'b1, 1'b0, 12'h084, 2'd0, 32'h000000FF, 32'h0,        8'd9},  // R9
        '{1'b0, 1'b1, 12'h084, 2'd0, 32'h0,        32'h00000005, 8'd9},  // R9
        '{1'b0, 1'b0, 12'h084, 2'd0, 32'h0,        32'h0,        8'd9},  // R9
        '{1'b0, 1'b0, 12'h420, 2'd2, 32'h0,        32'h00660022, 8'd6},  // R6
        '{1'b1, 1'b0, 12'h420, 2'd2, 32'h10203040, 32'h0,        8'd5},  // R5
        '{1'b0, 1'b1, 12'h420, 2'd2, 32'h0,        32'h449022A0, 8'd5},  // R5
        '{1'b0, 1'b0, 12'h420, 2'd2, 32'h0,        32'h00200040, 8'd6},  // R6
        '{1'b1, 1'b1, 12'h104, 2'd0, 32'h00000006, 32'h0,        8'd3},  // R3
        '{1'b0, 1'b1, 12'h104, 2'd0, 32'h0,        32'h00000006, 8'd9},  // R9
        '{1'b0, 1'b0, 12'h104, 2'd0, 32'h0,        32'h0,        8'd9},  // R9
        '{1'b1, 1'b1, 12'h41E, 2'd2, 32'hFFFFFFFF, 32'h0,        8'd8},  // R8
        '{1'b0, 1'b1, 12'h41C, 2'd2, 32'h0,        32'h0,        8'd8},  // R8
        '{1'b0, 1'b1, 12'h420, 2'd0, 32'h0,        32'h000000A0, 8'd8},  // R8
        '{1'b0, 1'b1, 12'h43E, 2'd2, 32'h0,        32'h0000AAAA, 8'd8},  // R8
        '{1'b1, 1'b1, 12'h43E, 2'd2, 32'h11223344, 32'h0,        8'd8},  // R8
        '{1'b0, 1'b1, 12'h43E, 2'd2, 32'h0,        32'h00003344, 8'd8},  // R8
        '{1'b0, 1'b1, 12'h800, 2'd2, 32'h0,        32'h0,        8'd10}, // R10
        '{1'b0, 1'b1, 12'h080, 2'd2, 32'h0,        32'h0,        8'd8}   // R8
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp,
                         input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic op(input logic wr, input logic sec, input logic [11:0] a,
                      input logic [1:0] sz, input logic [31:0] wd,
                      input logic [31:0] ex, input string tag);
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = wr;
        req_secure = sec;
        req_addr   = a;
        req_size   = sz;
        req_wdata  = wd;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        if (!wr)
            check(rd_data, ex, tag);
    endtask

    task automatic do_reset(input logic sd);
        @(negedge clk);
        rst = 1'b1;
        sec_disable = sd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 100000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fails);
        $finish;
    end

    initial begin
        do_reset(1'b0);

        // R1: reset state at the ports
        check(rd_data, 32'h0, "R1 rd_data");
        n_checks++;
        if (irq_prio !== {NUM_IRQ{8'hAA}}) begin
            n_fails++;
            $display("FAIL R1 irq_prio: actual %h expected all AA", irq_prio[31:0]);
        end
        check(32'(irq_group[63:0] != '0), 32'h0, "R1 irq_group zero");

        for (int k = 0; k < NV; k++)
            op(TBL[k].wr, TBL[k].sec, TBL[k].addr, TBL[k].sz, TBL[k].wd,
               TBL[k].ex, $sformatf("R%0d vec %0d", TBL[k].rq, k));

        // R10: idle cycle after a read returns zero
        op(1'b0, 1'b1, 12'h420, 2'd0, 32'h0, 32'h000000A0, "R10 read");
        @(negedge clk);
        check(rd_data, 32'h0, "R10 idle zero");

        // R3: derived group codes
        check(32'(irq_group[2*32 +: 2]), 32'h1, "R3 id32 grp1 mod0");
        check(32'(irq_group[2*33 +: 2]), 32'h2, "R3 id33 grp0 mod1");
        check(32'(irq_group[2*34 +: 2]), 32'h1, "R3 id34 grp1 mod1");
        check(32'(irq_group[2*35 +: 2]), 32'h0, "R3 id35 grp0 mod0");
        check(32'(irq_prio[8*48 +: 8]), 32'h5A, "R2 id48 prio port");

        // R4: security disabled
        do_reset(1'b1);
        op(1'b1, 1'b1, 12'h104, 2'd0, 32'hFF, 32'h0, "R4 mod write");
        op(1'b0, 1'b1, 12'h104, 2'd0, 32'h0, 32'h0, "R4 mod reads zero");
        check(32'(irq_group[2*33 +: 2]), 32'h0, "R4 mod ignored");
        op(1'b1, 1'b0, 12'h085, 2'd0, 32'h01, 32'h0, "R4 ns group write");
        op(1'b0, 1'b0, 12'h085, 2'd0, 32'h0, 32'h01, "R4 ns group read");
        check(32'(irq_group[2*40 +: 2]), 32'h1, "R4 id40 group");
        op(1'b1, 1'b0, 12'h428, 2'd0, 32'h7E, 32'h0, "R4 ns prio write");
        op(1'b0, 1'b0, 12'h428, 2'd0, 32'h0, 32'h7E, "R4 ns raw read");
        op(1'b0, 1'b1, 12'h428, 2'd0, 32'h0, 32'h7E, "R11 secure raw read");
        op(1'b1, 1'b0, 12'h429, 2'd0, 32'h33, 32'h0, "R4 ns write grp0");
        op(1'b0, 1'b0, 12'h429, 2'd0, 32'h0, 32'h33, "R4 ns read grp0");

        $display("  End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fails);
        $finish;
    end

endmodule